// File: doc/BRIEF.md
# Gated 16-bit Timer with Prescaler

This block is a 16-bit up-counter advanced by an external count-enable pulse (`tick_in`). Before a tick reaches the counter it must pass two qualifiers: a global run bit and, when gating is turned on, a gate signal. The gate signal is taken from one of four inputs and may be inverted. Qualified ticks feed a hidden prescaler that divides by 1, 2, 4 or 8. The prescaler's output pulse increments the counter.

Software reaches the block through a byte-wide register port with four addresses: counter low byte, counter high byte, control, and status. Writing either counter byte loads that byte and also clears the prescaler. When the counter wraps from FFFFh to 0000h, a sticky overflow flag is set. This flag stays set until software clears it.

Top module: `gated_timer16`

## Requirements
- R1: After reset the count is 0000h, the control register reads 00h and the overflow flag is 0.
- R2: Control bits [2:1] select the prescale ratio: 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8. The count rises by one on the clock edge that accepts the N-th qualified tick.
- R3: A write to address 0 (low byte) or address 1 (high byte) clears the prescaler. After such a write, N further qualified ticks are needed before the next increment.
- R4: While control bit 0 (run) is 0, neither the prescaler nor the count advances, whatever the gate and tick inputs do.
- R5: While control bit 3 (gate enable) is 0, every tick that arrives while running is qualified, whatever the gate inputs are.
- R6: With gate enable set, control bit 4 sets the polarity. With polarity 0, ticks are qualified only while the selected gate is 0. With polarity 1, ticks are qualified only while it is 1. Otherwise the count and the prescaler hold.
- R7: Control bits [6:5] choose the gate source: 00 is `gate_pin`, 01 is `t8_ovf` (the one-cycle wrap pulse of an 8-bit companion timer), 10 is `cmp1_in` and 11 is `cmp2_in`.
- R8: An increment from FFFFh produces 0000h and sets the overflow flag. The flag is visible on `ovf_flag` and in bit 0 of address 3 on the next cycle.
- R9: The overflow flag stays set until a write to address 3 with data bit 0 equal to 1. If a wrap and such a clear happen in the same cycle, the flag ends up set.
- R10: When a counter-byte write and an increment fall in the same cycle, the written byte takes the written value and the other byte takes its incremented value.
- R11: The read data is combinational on `reg_addr`. Address 0 returns count[7:0], 1 returns count[15:8], 2 returns the control register with bit 7 reading 0, and 3 returns the flag in bit 0 with the other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Count-enable pulse |
| gate_pin | input | 1 | Gate source 00 |
| t8_ovf | input | 1 | Companion 8-bit timer wrap pulse, gate source 01 |
| cmp1_in | input | 1 | Comparator 1 level, gate source 10 |
| cmp2_in | input | 1 | Comparator 2 level, gate source 11 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| count_value | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench targets the same-cycle collisions. The first is a counter-byte write together with an increment. A design that gives the increment priority loses the written byte; one that freezes the whole counter loses the carry into the other byte. The second is a wrap together with a flag clear. A design where the clear wins drops an overflow. It also checks that a byte write resets the prescaler phase. A design that keeps the phase increments early by the leftover ticks. Gated and stopped intervals must freeze the prescaler as well as the count; a prescaler that keeps running shifts every later increment. Each gate source and polarity is exercised with the other sources driven to the opposite level, so a swapped mux leg or an inverted polarity shows up as counting while it should hold.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    typedef enum logic [1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_CTRL   = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        GSRC_PIN   = 2'd0,
        GSRC_T8OVF = 2'd1,
        GSRC_CMP1  = 2'd2,
        GSRC_CMP2  = 2'd3
    } gate_src_e;

    // bit 0 run, [2:1] prescale select, 3 gate enable, 4 polarity, [6:5] source
    typedef struct packed {
        gate_src_e  gsrc;
        logic       gpol;
        logic       gen;
        logic [1:0] psel;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gtmr_gate_qual.sv
module gtmr_gate_qual #(
    parameter int NUM_SRC = 4,
    localparam int SRC_W = $clog2(NUM_SRC)
) (
    input  logic               tick,
    input  logic               run,
    input  logic               gate_en,
    input  logic               gate_pol,
    input  logic [SRC_W-1:0]   gate_sel,
    input  logic [NUM_SRC-1:0] gate_srcs,
    output logic               qual_tick
);
    logic raw_gate;
    logic gate_open;

    always_comb begin
        raw_gate  = gate_srcs[gate_sel];
        gate_open = gate_pol ? raw_gate : ~raw_gate;
        qual_tick = tick && run && (!gate_en || gate_open);
    end

endmodule

// File: rtl/gtmr_prescaler.sv
module gtmr_prescaler #(
    parameter int PS_SEL_W = 2,
    localparam int PC_W = (1 << PS_SEL_W) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PS_SEL_W-1:0] psel,
    input  logic                adv,
    input  logic                clr,
    output logic                pulse
);
    logic [PC_W-1:0] phase_q;
    logic [PC_W-1:0] phase_d;
    logic [PC_W-1:0] last_phase;

    always_comb begin
        last_phase = PC_W'((1 << psel) - 1);
        pulse      = adv && (phase_q >= last_phase);
        if (clr)
            phase_d = '0;
        else if (pulse)
            phase_d = '0;
        else if (adv)
            phase_d = phase_q + PC_W'(1);
        else
            phase_d = phase_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else
            phase_q <= phase_d;
    end

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> phase_q == '0);

    assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(phase_q));

    assert_div1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && psel == '0) |-> pulse);

endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);
    logic [CNT_W-1:0] bumped;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] count_d;

    always_comb begin
        bumped  = count + CNT_W'(1);
        base    = inc ? bumped : count;
        wrap    = inc && (&count);
        count_d = base;
        if (wr_lo) count_d[BYTE_W-1:0]     = wdata;
        if (wr_hi) count_d[CNT_W-1:BYTE_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else
            count <= count_d;
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_lo && !wr_hi) |=> count == $past(count) + CNT_W'(1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_lo && !wr_hi) |=> $stable(count));

    assert_lo_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> count[BYTE_W-1:0] == $past(wdata));

    assert_hi_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> count[CNT_W-1:BYTE_W] == $past(wdata));

endmodule

// File: rtl/gated_timer16.sv
module gated_timer16
    import gtmr_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PS_SEL_W = 2,
    parameter int NUM_SRC  = 4,
    localparam int CNT_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              gate_pin,
    input  logic              t8_ovf,
    input  logic              cmp1_in,
    input  logic              cmp2_in,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic [CNT_W-1:0]  count_value,
    output logic              ovf_flag
);
    ctrl_t ctrl_q;
    logic  flag_q;
    logic  wr_lo, wr_hi, wr_ctrl, wr_stat, flag_clr;
    logic  qual_tick, ps_pulse, wrap;
    logic [NUM_SRC-1:0] gate_srcs;

    always_comb begin
        wr_lo    = reg_wr && (reg_sel_e'(reg_addr) == REG_CNT_LO);
        wr_hi    = reg_wr && (reg_sel_e'(reg_addr) == REG_CNT_HI);
        wr_ctrl  = reg_wr && (reg_sel_e'(reg_addr) == REG_CTRL);
        wr_stat  = reg_wr && (reg_sel_e'(reg_addr) == REG_STAT);
        flag_clr = wr_stat && reg_wdata[0];
        gate_srcs = '0;
        gate_srcs[GSRC_PIN]   = gate_pin;
        gate_srcs[GSRC_T8OVF] = t8_ovf;
        gate_srcs[GSRC_CMP1]  = cmp1_in;
        gate_srcs[GSRC_CMP2]  = cmp2_in;
    end

    gtmr_gate_qual #(.NUM_SRC(NUM_SRC)) u_gate (
        .tick      (tick_in),
        .run       (ctrl_q.run),
        .gate_en   (ctrl_q.gen),
        .gate_pol  (ctrl_q.gpol),
        .gate_sel  (ctrl_q.gsrc),
        .gate_srcs (gate_srcs),
        .qual_tick (qual_tick)
    );

    gtmr_prescaler #(.PS_SEL_W(PS_SEL_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .psel  (ctrl_q.psel),
        .adv   (qual_tick),
        .clr   (wr_lo || wr_hi),
        .pulse (ps_pulse)
    );

    gtmr_counter #(.BYTE_W(BYTE_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ps_pulse),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (reg_wdata),
        .count (count_value),
        .wrap  (wrap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (wrap)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    assign ovf_flag = flag_q;

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            REG_CNT_LO: reg_rdata = count_value[BYTE_W-1:0];
            REG_CNT_HI: reg_rdata = count_value[CNT_W-1:BYTE_W];
            REG_CTRL:   reg_rdata = BYTE_W'(ctrl_q);
            REG_STAT:   reg_rdata = BYTE_W'(flag_q);
            default:    reg_rdata = '0;
        endcase
    end

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_flag);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    assert_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_lo && !wr_hi) |=> $stable(count_value));

    assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(count_value) == '1);

endmodule

// File: tb/gated_timer16_test.sv
module gated_timer16_test;
    localparam int CLK_P = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic tick_in = 0, gate_pin = 0, t8_ovf = 0, cmp1_in = 0, cmp2_in = 0;
    logic reg_wr = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic [15:0] count_value;
    logic ovf_flag;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    int m_cnt = 0, m_pc = 0;
    bit m_flag = 0;
    int m_ctrl = 0;

    always #(CLK_P/2) clk = ~clk;

    gated_timer16 uut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .gate_pin(gate_pin),
        .t8_ovf(t8_ovf), .cmp1_in(cmp1_in), .cmp2_in(cmp2_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .count_value(count_value), .ovf_flag(ovf_flag)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_flag = 0; m_ctrl = 0;
        end else begin
            bit raw, act, q, pulse, wrapped, clr;
            int n, nxt;
            case ((m_ctrl >> 5) & 3)
                0: raw = gate_pin;
                1: raw = t8_ovf;
                2: raw = cmp1_in;
                default: raw = cmp2_in;
            endcase
            act = ((m_ctrl >> 4) & 1) != 0 ? raw : !raw;
            q = tick_in && ((m_ctrl & 1) != 0) && (((m_ctrl >> 3) & 1) == 0 || act);
            n = 1 << ((m_ctrl >> 1) & 3);
            pulse = 0;
            if (q) begin
                m_pc = m_pc + 1;
                if (m_pc >= n) begin pulse = 1; m_pc = 0; end
            end
            wrapped = pulse && (m_cnt == 16'hFFFF);
            nxt = pulse ? ((m_cnt + 1) % 65536) : m_cnt;
            clr = 0;
            if (reg_wr) begin
                case (reg_addr)
                    0: begin nxt = (nxt & 16'hFF00) | reg_wdata; m_pc = 0; end
                    1: begin nxt = (nxt & 16'h00FF) | (int'(reg_wdata) << 8); m_pc = 0; end
                    2: m_ctrl = reg_wdata & 8'h7F;
                    default: clr = reg_wdata[0];
                endcase
            end
            m_cnt = nxt;
            if (wrapped) m_flag = 1;
            else if (clr) m_flag = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model count", count_value, m_cnt);
            chk("R8 model flag", ovf_flag, m_flag);
        end
    end

    task automatic drive(input bit tk, input bit wr, input int addr, input int data);
        @(negedge clk);
        tick_in = tk; reg_wr = wr; reg_addr = addr[1:0]; reg_wdata = data[7:0];
    endtask

    task automatic idle();
        @(negedge clk);
        tick_in = 0; reg_wr = 0; #1;
    endtask

    task automatic wr(input int addr, input int data);
        drive(0, 1, addr, data);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) drive(1, 0, 0, 0);
    endtask

    task automatic rd_chk(input string req, input int addr, input int exp);
        @(negedge clk);
        tick_in = 0; reg_wr = 0; reg_addr = addr[1:0]; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic load(input int v);
        wr(0, v & 255); wr(1, (v >> 8) & 255);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        // R1 reset state
        chk("R1 count", count_value, 0);
        chk("R1 flag", ovf_flag, 0);
        rd_chk("R1 ctrl", 2, 0);

        // R5 free run divide by 1, gate inputs active against it
        gate_pin = 1; cmp1_in = 1; cmp2_in = 1;
        wr(2, 8'h01); ticks(5); idle();
        chk("R5 free count", count_value, 5);

        // R2 divide by 4, R3 write clears prescaler
        load(0); wr(2, 8'h05); ticks(7); idle();
        chk("R2 div4", count_value, 1);
        wr(0, 0); ticks(3); idle();
        chk("R3 cleared phase", count_value, 0);
        ticks(1); idle();
        chk("R3 full period", count_value, 1);
        // divide by 8
        load(0); wr(2, 8'h07); ticks(16); idle();
        chk("R2 div8", count_value, 2);

        // R4 stopped
        load(16'h0040); wr(2, 8'h00); ticks(10); idle();
        chk("R4 stopped", count_value, 16'h0040);
        wr(2, 8'h03); ticks(1); idle();
        chk("R4 prescaler frozen", count_value, 16'h0040);
        ticks(1); idle();
        chk("R4 resumed div2", count_value, 16'h0041);

        // R6/R7 pin source, polarity 0
        load(0); wr(2, 8'h09); gate_pin = 1; ticks(4); idle();
        chk("R6 pol0 holds on 1", count_value, 0);
        gate_pin = 0; ticks(4); idle();
        chk("R6 pol0 counts on 0", count_value, 4);
        wr(2, 8'h19); ticks(3); idle();
        chk("R6 pol1 holds on 0", count_value, 4);
        gate_pin = 1; ticks(3); idle();
        chk("R6 pol1 counts on 1", count_value, 7);

        // R7 companion overflow source, others driven high
        load(0); wr(2, 8'h39); gate_pin = 1; cmp1_in = 1; cmp2_in = 1; t8_ovf = 0;
        ticks(4); idle();
        chk("R7 t8 src holds", count_value, 0);
        t8_ovf = 1; ticks(2); idle(); t8_ovf = 0;
        chk("R7 t8 src counts", count_value, 2);
        // cmp1, others low
        load(0); wr(2, 8'h59); gate_pin = 0; cmp2_in = 0; cmp1_in = 0;
        ticks(3); idle();
        chk("R7 cmp1 holds", count_value, 0);
        cmp1_in = 1; ticks(3); idle();
        chk("R7 cmp1 counts", count_value, 3);
        // cmp2
        load(0); wr(2, 8'h79); cmp1_in = 1; cmp2_in = 0; ticks(3); idle();
        chk("R7 cmp2 holds", count_value, 0);
        cmp2_in = 1; ticks(2); idle();
        chk("R7 cmp2 counts", count_value, 2);

        // R8 wrap and flag
        wr(2, 8'h01); load(16'hFFFE); ticks(1); idle();
        chk("R8 no flag before wrap", ovf_flag, 0);
        ticks(1); idle();
        chk("R8 wrap count", count_value, 0);
        chk("R8 flag set", ovf_flag, 1);
        rd_chk("R11 status read", 3, 1);
        ticks(3); wr(3, 0); idle();
        chk("R9 sticky", ovf_flag, 1);
        wr(3, 1); idle();
        chk("R9 cleared", ovf_flag, 0);
        load(16'hFFFF); drive(1, 1, 3, 1); idle();
        chk("R9 set wins", ovf_flag, 1);

        // R10 collisions
        load(16'h00FF); drive(1, 1, 1, 8'h12); idle();
        chk("R10 high write, low incremented", count_value, 16'h1200);
        load(16'h12FF); drive(1, 1, 0, 8'h34); idle();
        chk("R10 low write, high incremented", count_value, 16'h1334);

        // R11 reads
        load(16'hA55A); wr(2, 8'h7B);
        rd_chk("R11 low", 0, 8'h5A);
        rd_chk("R11 high", 1, 8'hA5);
        rd_chk("R11 ctrl", 2, 8'h7B);
        wr(2, 8'hFF);
        rd_chk("R11 ctrl bit7 zero", 2, 8'h7F);

        // mixed random phase checked by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            @(negedge clk);
            gate_pin = $urandom_range(0, 1); t8_ovf = $urandom_range(0, 1);
            cmp1_in = $urandom_range(0, 1); cmp2_in = $urandom_range(0, 1);
            tick_in = $urandom_range(0, 3) != 0;
            reg_wr = r < 8;
            reg_addr = $urandom_range(0, 3);
            reg_wdata = $urandom_range(0, 255);
            if (reg_wr && reg_addr == 2) reg_wdata[0] = 1;
            if (reg_wr && reg_addr == 1 && r < 4) reg_wdata = 8'hFF;
        end
        idle();
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule